// File: doc/BRIEF.md
# Frame Status Event and Interrupt Gate

This block sits between the receive and transmit paths of a network MAC and the host interrupt line. The receive path presents one status pulse per finished frame, carrying four condition flags and the frame length. The block decides in the same cycle whether the frame is kept or thrown away. A thrown-away frame is reported with a length of zero. The block also records every condition in a sticky event bit and raises an interrupt for each condition whose enable bit is set.

The interrupt enable and the accept bit of a receive condition class are separate controls. Software can therefore ask to be told about a bad frame without keeping it, or keep it silently. The block applies the same event-and-enable scheme to seven transmit outcomes and to six buffer-level pulses. It also runs two 10-bit counters, one for transmit collisions and one for missed receive frames. Each counter can interrupt when it climbs past 1FFh, and each clears when software reads it.

Top module: `frame_evt_irq`

## Requirements
- R1: Receive flags use bit 0 = oversize, bit 1 = runt, bit 2 = CRC error and bit 3 = good frame. On a cycle with `rx_stat_vld` high, each set flag sets the same bit of `rx_evt` at the next edge. The bits hold until `rx_evt_clr`. If a set and a clear fall in the same cycle, the set wins.
- R2: On a status cycle, a frame is dropped if any of bits 0..2 is set while the matching `rx_acc` bit is clear. A dropped frame shows `rx_drop`=1, `rx_keep`=0 and `rx_len_out`=0 in that same cycle.
- R3: A frame with bit 3 set is kept only if `rx_acc[3]` is set. A kept frame shows `rx_keep`=1 and `rx_len_out`=`rx_len_in` in the status cycle. A status with no flags at all is kept.
- R4: `irq` is high whenever any `rx_evt` bit and its `rx_ie` bit are both set. This happens whether or not the frame was accepted, so an enabled but unaccepted condition both interrupts and drops the frame.
- R5: Transmit flags use bit 0 = sixteen collisions, 1 = any collision, 2 = jabber, 3 = late collision, 4 = sent OK, 5 = SQE error and 6 = carrier lost. They set `tx_evt` the same way R1 describes, are cleared by `tx_evt_clr`, and reach `irq` through `tx_ie`.
- R6: Buffer pulses use bit 0 = address match, 1 = 128 bytes in, 2 = receive miss, 3 = transmit underrun, 4 = ready to send and 5 = receive DMA frame. Each pulse sets its bit of `buf_evt` and reaches `irq` through `buf_ie`. The bits are cleared by `buf_evt_clr`.
- R7: Each cycle with `tx_coll_pulse` high adds one to `col_cnt`. Each cycle with `rx_miss_pulse` high adds one to `miss_cnt`.
- R8: A read strobe clears its counter. An increment that falls in the same cycle as the read leaves the counter at 1.
- R9: A step from 1FFh to 200h sets that counter's overflow flag (`col_ovf` or `miss_ovf`). The flag holds until the counter is read and drives `irq` when its enable is set.
- R10: Out of reset, all event bits, counters and overflow flags are zero, and `irq`, `rx_keep` and `rx_drop` are low. Without `rx_stat_vld`, `rx_keep` and `rx_drop` stay low and `rx_len_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stat_vld | input | 1 | Receive frame status pulse |
| rx_stat | input | 4 | Receive condition flags |
| rx_len_in | input | LEN_W | Received frame length |
| rx_ie | input | 4 | Receive interrupt enables |
| rx_acc | input | 4 | Receive accept bits |
| rx_keep | output | 1 | Frame kept |
| rx_drop | output | 1 | Frame dropped |
| rx_len_out | output | LEN_W | Reported length, zero when dropped |
| rx_evt | output | 4 | Sticky receive events |
| rx_evt_clr | input | 1 | Clear receive events |
| tx_stat_vld | input | 1 | Transmit status pulse |
| tx_stat | input | 7 | Transmit condition flags |
| tx_ie | input | 7 | Transmit interrupt enables |
| tx_evt | output | 7 | Sticky transmit events |
| tx_evt_clr | input | 1 | Clear transmit events |
| tx_coll_pulse | input | 1 | One transmit collision |
| rx_miss_pulse | input | 1 | One missed receive frame |
| col_cnt | output | CNT_W | Collision count |
| miss_cnt | output | CNT_W | Missed-frame count |
| col_cnt_rd | input | 1 | Read-clear of collision count |
| miss_cnt_rd | input | 1 | Read-clear of missed count |
| col_ovf_ie | input | 1 | Collision overflow interrupt enable |
| miss_ovf_ie | input | 1 | Missed overflow interrupt enable |
| col_ovf | output | 1 | Collision counter overflow flag |
| miss_ovf | output | 1 | Missed counter overflow flag |
| buf_pulse | input | 6 | Buffer condition pulses |
| buf_ie | input | 6 | Buffer interrupt enables |
| buf_evt | output | 6 | Sticky buffer events |
| buf_evt_clr | input | 1 | Clear buffer events |
| irq | output | 1 | Interrupt request |

## Verification
A wrong accept decision is combinational, so it shows on `rx_keep`, `rx_drop` or `rx_len_out` in the status cycle itself. A lost or stuck event bit shows on its event port and on `irq` one edge after the pulse or clear that should have changed it. A counter that is off by one at any point stays wrong on `col_cnt` or `miss_cnt` until the next read. A counter fault near the threshold shows on the overflow flag one edge after the 512th increment, which the bench reaches by counting up to it.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam int RX_N  = 4;
    localparam int TX_N  = 7;
    localparam int BUF_N = 6;

    // receive flag positions
    localparam int RX_BIG  = 0;
    localparam int RX_RUNT = 1;
    localparam int RX_CRC  = 2;
    localparam int RX_GOOD = 3;

    // counter selector used by the counter generate loop
    localparam int CNT_COL  = 0;
    localparam int CNT_MISS = 1;
    localparam int CNT_NUM  = 2;
endpackage

// File: rtl/fe_rx_accept.sv
module fe_rx_accept
    import fe_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             vld,
    input  logic [RX_N-1:0]  stat,
    input  logic [RX_N-1:0]  acc,
    input  logic [LEN_W-1:0] len_in,
    output logic             keep,
    output logic             drop,
    output logic [LEN_W-1:0] len_out
);
    localparam int ERR_N = RX_GOOD;

    logic [ERR_N-1:0] err_refused;
    logic             good_refused;
    logic             ok;

    always_comb begin
        err_refused  = stat[ERR_N-1:0] & ~acc[ERR_N-1:0];
        good_refused = stat[RX_GOOD] & ~acc[RX_GOOD];
        ok           = ~(|err_refused) & ~good_refused;
        keep         = vld & ok;
        drop         = vld & ~ok;
        len_out      = keep ? len_in : '0;
    end
endmodule

// File: rtl/fe_evt_reg.sv
module fe_evt_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] evt
);
    typedef struct packed {
        logic [W-1:0] bits;
    } evt_state_t;

    evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.bits = '0;
        end
        if (vld) begin
            st_d.bits = st_d.bits | set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt = st_q.bits;
endmodule

// File: rtl/fe_ovf_counter.sv
module fe_ovf_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             rd,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] EDGE_VAL = {1'b0, {(CNT_W-1){1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
        end
        if (inc) begin
            st_d.cnt = st_d.cnt + 1'b1;
            if (!rd && st_q.cnt == EDGE_VAL) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;
endmodule

// File: rtl/frame_evt_irq.sv
module frame_evt_irq
    import fe_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_stat_vld,
    input  logic [3:0]       rx_stat,
    input  logic [LEN_W-1:0] rx_len_in,
    input  logic [3:0]       rx_ie,
    input  logic [3:0]       rx_acc,
    output logic             rx_keep,
    output logic             rx_drop,
    output logic [LEN_W-1:0] rx_len_out,
    output logic [3:0]       rx_evt,
    input  logic             rx_evt_clr,
    input  logic             tx_stat_vld,
    input  logic [6:0]       tx_stat,
    input  logic [6:0]       tx_ie,
    output logic [6:0]       tx_evt,
    input  logic             tx_evt_clr,
    input  logic             tx_coll_pulse,
    input  logic             rx_miss_pulse,
    output logic [CNT_W-1:0] col_cnt,
    output logic [CNT_W-1:0] miss_cnt,
    input  logic             col_cnt_rd,
    input  logic             miss_cnt_rd,
    input  logic             col_ovf_ie,
    input  logic             miss_ovf_ie,
    output logic             col_ovf,
    output logic             miss_ovf,
    input  logic [5:0]       buf_pulse,
    input  logic [5:0]       buf_ie,
    output logic [5:0]       buf_evt,
    input  logic             buf_evt_clr,
    output logic             irq
);
    fe_rx_accept #(.LEN_W(LEN_W)) u_acc (
        .vld     (rx_stat_vld),
        .stat    (rx_stat),
        .acc     (rx_acc),
        .len_in  (rx_len_in),
        .keep    (rx_keep),
        .drop    (rx_drop),
        .len_out (rx_len_out)
    );

    fe_evt_reg #(.W(RX_N)) u_rx_evt (
        .clk (clk), .rst_n (rst_n), .vld (rx_stat_vld),
        .set (rx_stat), .clr (rx_evt_clr), .evt (rx_evt)
    );

    fe_evt_reg #(.W(TX_N)) u_tx_evt (
        .clk (clk), .rst_n (rst_n), .vld (tx_stat_vld),
        .set (tx_stat), .clr (tx_evt_clr), .evt (tx_evt)
    );

    fe_evt_reg #(.W(BUF_N)) u_buf_evt (
        .clk (clk), .rst_n (rst_n), .vld (|buf_pulse),
        .set (buf_pulse), .clr (buf_evt_clr), .evt (buf_evt)
    );

    logic [CNT_NUM-1:0]   c_inc, c_rd, c_ovf, c_ie;
    logic [CNT_W-1:0]     c_val [CNT_NUM];

    assign c_inc[CNT_COL]  = tx_coll_pulse;
    assign c_inc[CNT_MISS] = rx_miss_pulse;
    assign c_rd[CNT_COL]   = col_cnt_rd;
    assign c_rd[CNT_MISS]  = miss_cnt_rd;
    assign c_ie[CNT_COL]   = col_ovf_ie;
    assign c_ie[CNT_MISS]  = miss_ovf_ie;

    for (genvar g = 0; g < CNT_NUM; g++) begin : g_cnt
        fe_ovf_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (c_inc[g]),
            .rd    (c_rd[g]),
            .cnt   (c_val[g]),
            .ovf   (c_ovf[g])
        );
    end

    assign col_cnt  = c_val[CNT_COL];
    assign miss_cnt = c_val[CNT_MISS];
    assign col_ovf  = c_ovf[CNT_COL];
    assign miss_ovf = c_ovf[CNT_MISS];

    always_comb begin
        irq = (|(rx_evt & rx_ie)) | (|(tx_evt & tx_ie)) |
              (|(buf_evt & buf_ie)) | (|(c_ovf & c_ie));
    end
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_stat_vld,
    input logic [3:0]       rx_stat,
    input logic [3:0]       rx_ie,
    input logic             rx_keep,
    input logic             rx_drop,
    input logic [LEN_W-1:0] rx_len_out,
    input logic [3:0]       rx_evt,
    input logic             rx_evt_clr,
    input logic             tx_stat_vld,
    input logic [6:0]       tx_stat,
    input logic [6:0]       tx_evt,
    input logic             tx_coll_pulse,
    input logic [CNT_W-1:0] col_cnt,
    input logic             col_cnt_rd,
    input logic             col_ovf,
    input logic             irq
);
    localparam logic [CNT_W-1:0] EDGE_VAL = {1'b0, {(CNT_W-1){1'b1}}};

    p_drop_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |-> (rx_len_out == '0 && !rx_keep));

    p_decision_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_stat_vld |-> (!rx_keep && !rx_drop));

    p_rx_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stat_vld |=> ((rx_evt & $past(rx_stat)) == $past(rx_stat)));

    p_rx_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt_clr && !rx_stat_vld) |=> (rx_evt == '0));

    p_tx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stat_vld |=> ((tx_evt & $past(tx_stat)) == $past(tx_stat)));

    p_irq_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rx_evt & rx_ie)) |-> irq);

    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_coll_pulse && !col_cnt_rd) |=> $stable(col_cnt));

    p_cnt_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_cnt_rd && !tx_coll_pulse) |=> (col_cnt == '0));

    p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_coll_pulse && !col_cnt_rd && col_cnt == EDGE_VAL) |=> col_ovf);
endmodule

bind frame_evt_irq fe_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_frame_evt_irq.sv
`timescale 1ns/1ps
module sim_frame_evt_irq;
    localparam int LEN_W = 12;
    localparam int CNT_W = 10;
    localparam int NVEC  = 12;

    logic clk = 1'b0;
    logic rst_n;
    always #2.5 clk = ~clk;

    logic             rx_stat_vld, rx_evt_clr, tx_stat_vld, tx_evt_clr;
    logic [3:0]       rx_stat, rx_ie, rx_acc, rx_evt;
    logic [LEN_W-1:0] rx_len_in, rx_len_out;
    logic             rx_keep, rx_drop;
    logic [6:0]       tx_stat, tx_ie, tx_evt;
    logic             tx_coll_pulse, rx_miss_pulse, col_cnt_rd, miss_cnt_rd;
    logic             col_ovf_ie, miss_ovf_ie, col_ovf, miss_ovf;
    logic [CNT_W-1:0] col_cnt, miss_cnt;
    logic [5:0]       buf_pulse, buf_ie, buf_evt;
    logic             buf_evt_clr, irq;

    frame_evt_irq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // {flags[3:0], ie[3:0], acc[3:0], keep, irq}; flag bits: 0 big, 1 runt, 2 crc, 3 good
    localparam logic [13:0] VEC [NVEC] = '{
        {4'b1000, 4'b0000, 4'b1000, 1'b1, 1'b0},
        {4'b1000, 4'b1000, 4'b0000, 1'b0, 1'b1},
        {4'b0100, 4'b0100, 4'b0000, 1'b0, 1'b1},
        {4'b0100, 4'b0000, 4'b0100, 1'b1, 1'b0},
        {4'b0010, 4'b0000, 4'b0000, 1'b0, 1'b0},
        {4'b0010, 4'b0010, 4'b0010, 1'b1, 1'b1},
        {4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b1},
        {4'b0101, 4'b0000, 4'b0001, 1'b0, 1'b0},
        {4'b0101, 4'b0100, 4'b0101, 1'b1, 1'b1},
        {4'b1001, 4'b0000, 4'b0001, 1'b0, 1'b0},
        {4'b0000, 4'b1111, 4'b0000, 1'b1, 1'b0},
        {4'b1000, 4'b0111, 4'b1000, 1'b1, 1'b0}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        rx_stat_vld = 0; rx_stat = 0; rx_len_in = 0; rx_ie = 0; rx_acc = 0; rx_evt_clr = 0;
        tx_stat_vld = 0; tx_stat = 0; tx_ie = 0; tx_evt_clr = 0;
        tx_coll_pulse = 0; rx_miss_pulse = 0; col_cnt_rd = 0; miss_cnt_rd = 0;
        col_ovf_ie = 0; miss_ovf_ie = 0; buf_pulse = 0; buf_ie = 0; buf_evt_clr = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R10 reset state
        check("R10 rx_evt", rx_evt, 0);
        check("R10 tx_evt", tx_evt, 0);
        check("R10 counters", {col_cnt, miss_cnt}, 0);
        check("R10 ovf/irq/keep/drop", {col_ovf, miss_ovf, irq, rx_keep, rx_drop}, 0);
        rx_len_in = 12'h3AB;
        #1;
        check("R10 len without status", rx_len_out, 0);

        // R2 R3 R4 table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] f, ie, ac;
            logic ek, ei;
            {f, ie, ac, ek, ei} = VEC[i];
            rx_stat_vld = 1; rx_stat = f; rx_ie = ie; rx_acc = ac;
            rx_len_in = 12'h040 + 12'(i);
            #1;
            check($sformatf("R2/R3 keep vec%0d", i), {rx_keep, rx_drop}, {ek, ~ek});
            check($sformatf("R2/R3 len vec%0d", i), rx_len_out, ek ? 12'h040 + 12'(i) : 12'h0);
            step();
            rx_stat_vld = 0;
            #1;
            check($sformatf("R1 evt vec%0d", i), rx_evt, f);
            check($sformatf("R4 irq vec%0d", i), irq, ei);
            rx_evt_clr = 1;
            step();
            rx_evt_clr = 0;
            check($sformatf("R1 clear vec%0d", i), rx_evt, 0);
        end

        // R1 set wins over clear in the same cycle; old bits cleared
        rx_ie = 0;
        rx_stat_vld = 1; rx_stat = 4'b0001; step();
        rx_stat = 4'b0100; rx_evt_clr = 1; step();
        rx_stat_vld = 0; rx_evt_clr = 0;
        check("R1 set beats clear", rx_evt, 4'b0100);
        rx_evt_clr = 1; step(); rx_evt_clr = 0;

        // R5 transmit events
        tx_ie = 7'b0010000;
        tx_stat_vld = 1; tx_stat = 7'b1000101; step();
        tx_stat_vld = 0; tx_stat = 0;
        check("R5 tx evt", tx_evt, 7'b1000101);
        check("R5 tx irq masked", irq, 0);
        tx_stat_vld = 1; tx_stat = 7'b0010000; step();
        tx_stat_vld = 0; tx_stat = 0;
        check("R5 tx irq enabled", irq, 1);
        tx_evt_clr = 1; step(); tx_evt_clr = 0;
        check("R5 tx clear", {tx_evt, irq}, 0);

        // R6 buffer events
        buf_ie = 6'b100000;
        buf_pulse = 6'b001010; step(); buf_pulse = 0;
        check("R6 buf evt", buf_evt, 6'b001010);
        check("R6 buf irq masked", irq, 0);
        buf_pulse = 6'b100000; step(); buf_pulse = 0;
        check("R6 buf irq", {buf_evt, irq}, {6'b101010, 1'b1});
        buf_evt_clr = 1; step(); buf_evt_clr = 0;
        check("R6 buf clear", {buf_evt, irq}, 0);

        // R7 R8 missed counter
        rx_miss_pulse = 1; repeat (3) step(); rx_miss_pulse = 0;
        check("R7 miss count", miss_cnt, 3);
        miss_cnt_rd = 1; step(); miss_cnt_rd = 0;
        check("R8 miss read clears", miss_cnt, 0);

        // R7 R9 collision counter to threshold
        col_ovf_ie = 1;
        tx_coll_pulse = 1; repeat (511) step(); tx_coll_pulse = 0;
        check("R7 col count 1FF", col_cnt, 10'h1FF);
        check("R9 no ovf at 1FF", {col_ovf, irq}, 0);
        tx_coll_pulse = 1; step(); tx_coll_pulse = 0;
        check("R9 col count 200", col_cnt, 10'h200);
        check("R9 ovf and irq", {col_ovf, irq}, 2'b11);
        step();
        check("R9 ovf sticky", col_ovf, 1);
        tx_coll_pulse = 1; col_cnt_rd = 1; step();
        tx_coll_pulse = 0; col_cnt_rd = 0;
        check("R8 read with inc", col_cnt, 1);
        check("R9 ovf cleared by read", {col_ovf, irq}, 0);

        // R9 missed counter overflow, masked then enabled
        miss_cnt_rd = 1; step(); miss_cnt_rd = 0;
        rx_miss_pulse = 1; repeat (512) step(); rx_miss_pulse = 0;
        check("R9 miss ovf masked", {miss_cnt, miss_ovf, irq}, {10'h200, 1'b1, 1'b0});
        miss_ovf_ie = 1; #1;
        check("R9 miss ovf irq", irq, 1);

        finish_run();
    end
endmodule